// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus that behaves as a small byte-organised EEPROM. Its storage is an internal register array whose size is set by a density parameter in kilobits: 1, 2, 4, 8 or 16. The bus clock and data lines are sampled by a faster system clock through a two-stage synchroniser. The block pulls the data line low through an open-drain enable and never drives it high.

A master can store data as a single byte or as a burst of up to one page. It can fetch data at the current address, at an address it first loads with a write header, or as a sequential stream that continues while it acknowledges each byte. A completed store starts a self-timed write cycle. The length of that cycle is a parameter counted in system clocks. While the cycle runs the slave gives no acknowledge, so a master can poll its address until the slave answers again. A write-protect input blocks storage. Hard-wired pin-address inputs select the device on a shared bus. As density grows, the upper word-address bits travel in the device-address byte and displace pin-address bits.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A falling data edge while the clock is high is a start; a rising data edge while the clock is high is a stop. A start that arrives in the middle of a byte abandons the transfer and begins a new address byte. A partly received data byte is not stored, and the address counter keeps its value.
- R2: The address byte carries 1010 in bits 7:4 and a read/write flag in bit 0, where 1 means read. At 1K/2K, bits 3:1 must equal the pin address. At 4K, bits 3:2 are compared and bit 1 is word-address bit 8. At 8K, bit 3 is compared and bits 2:1 are word-address bits 9:8. At 16K, bits 3:1 are word-address bits 10:8. With pin address 101 at 2K, the write byte is 0xAA and the read byte is 0xAB. A matching byte is acknowledged by pulling data low during the ninth clock.
- R3: On a non-matching address byte the slave gives no acknowledge and stays silent until the next start.
- R4: In a write, the word-address byte and every data byte are acknowledged, and each data byte is stored at the address counter.
- R5: During a write only the low page bits of the address counter advance. The page is 8 bytes at 1K/2K and 16 bytes above that, so bytes beyond one page wrap to the start of the same page.
- R6: A stop after at least one stored data byte starts a write cycle of WRITE_CYCLES system clocks. During that cycle no address byte is acknowledged and data is never pulled low. Once the cycle ends, address bytes are acknowledged again.
- R7: A read without a preceding word address returns the byte at the address that follows the last byte accessed.
- R8: A write header with only a word address, followed by a repeated start and a read byte, returns the byte at that word address.
- R9: A master acknowledge after a read byte makes the slave send the next byte, with the address wrapping from the last byte of the array to byte 0. A master non-acknowledge ends the read.
- R10: While write-protect is high, data bytes are still acknowledged but are not stored, and no write cycle starts.
- R11: A stop in the middle of a data byte discards that partial byte. Complete bytes before it are kept.
- R12: The slave begins pulling data low only while the clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen on the wire |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| sdaDriveLow | output | 1 | Open-drain enable; 1 pulls the data line low |
| writeProtect | input | 1 | 1 blocks storage of write data |
| pinAddr | input | 3 | Hard-wired device pin address |

## Verification
Each bus edge passes through two synchroniser stages and one edge register, so a pull-low that answers a clock fall is visible four system clocks after the raw fall. The bench samples it in the middle of the following clock-high phase, at least ten clocks later. A write cycle begins four clocks after the raw stop edge and holds for exactly WRITE_CYCLES clocks. The bench therefore expects the first poll to be refused and accepts the first acknowledge only once that many clocks have passed since the stop. The reference memory and address counter in the bench apply the page-wrap and array-wrap rules on their own. Silence is compared against the drive on every system clock inside windows where the model requires it, and every new pull-low is checked against the raw clock level at that clock.

// File: rtl/seep_pkg.sv
package seep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDATA,
    ST_RDATA
  } busState_t;

  typedef struct packed {
    logic shiftRx;
    logic captureDev;
    logic loadWordAddr;
    logic writeByte;
    logic loadTx;
    logic shiftTx;
    logic startTimer;
  } dpStrobe_t;

endpackage

// File: rtl/seep_ctrl.sv
module seep_ctrl
  import seep_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      writeProtect,
  input  logic      addrMatch,
  input  logic      devRead,
  input  logic      txBit,
  output logic      sampleBit,
  output dpStrobe_t stb,
  output logic      sdaDriveLow
);

  logic [2:0] sclPipe, sdaPipe;
  logic sclNow, sclOld, sdaNow, sdaOld;
  logic startEv, stopEv, riseEv, fallEv;

  busState_t state;
  logic [3:0] bitCnt;
  logic ackDrive, txActive, masterAck, dataSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[1:0], sclIn};
      sdaPipe <= {sdaPipe[1:0], sdaIn};
    end
  end

  assign sclNow  = sclPipe[1];
  assign sclOld  = sclPipe[2];
  assign sdaNow  = sdaPipe[1];
  assign sdaOld  = sdaPipe[2];
  assign startEv = sclNow & sclOld & sdaOld & ~sdaNow;
  assign stopEv  = sclNow & sclOld & ~sdaOld & sdaNow;
  assign riseEv  = sclNow & ~sclOld;
  assign fallEv  = ~sclNow & sclOld;
  assign sampleBit = sdaNow;

  always_comb begin
    stb = '0;
    if (stopEv && dataSeen) stb.startTimer = 1'b1;
    if (!startEv && !stopEv && state != ST_IDLE) begin
      if (riseEv && bitCnt < 4'd8 && state != ST_RDATA) stb.shiftRx = 1'b1;
      if (fallEv) begin
        if (bitCnt >= 4'd1 && bitCnt <= 4'd7 && state == ST_RDATA) stb.shiftTx = 1'b1;
        if (bitCnt == 4'd8) begin
          stb.captureDev   = (state == ST_DEV);
          stb.loadWordAddr = (state == ST_WORD);
          stb.writeByte    = (state == ST_WDATA) && !writeProtect;
        end
        if (bitCnt == 4'd9)
          stb.loadTx = (state == ST_DEV && devRead) || (state == ST_RDATA && masterAck);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      txActive  <= 1'b0;
      masterAck <= 1'b0;
      dataSeen  <= 1'b0;
    end else if (startEv) begin
      state    <= ST_DEV;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else if (stopEv) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
      dataSeen <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (riseEv && bitCnt < 4'd9) begin
        if (bitCnt == 4'd8) masterAck <= ~sdaNow;
        bitCnt <= bitCnt + 4'd1;
      end
      if (fallEv && bitCnt == 4'd8) begin
        case (state)
          ST_DEV:   if (addrMatch) ackDrive <= 1'b1; else state <= ST_IDLE;
          ST_WORD:  ackDrive <= 1'b1;
          ST_WDATA: begin
            ackDrive <= 1'b1;
            if (!writeProtect) dataSeen <= 1'b1;
          end
          default:  txActive <= 1'b0;
        endcase
      end
      if (fallEv && bitCnt == 4'd9) begin
        bitCnt   <= '0;
        ackDrive <= 1'b0;
        case (state)
          ST_DEV: begin
            if (devRead) begin
              state    <= ST_RDATA;
              txActive <= 1'b1;
            end else begin
              state <= ST_WORD;
            end
          end
          ST_WORD: state <= ST_WDATA;
          ST_RDATA: begin
            if (masterAck) txActive <= 1'b1;
            else begin
              txActive <= 1'b0;
              state    <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaDriveLow = ackDrive | (txActive & ~txBit);

endmodule

// File: rtl/seep_dpath.sv
module seep_dpath
  import seep_pkg::*;
#(
  parameter int MEM_BYTES    = 256,
  parameter int ADDR_W       = 8,
  parameter int PAGE_W       = 3,
  parameter int HI_BITS      = 0,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic       sampleBit,
  input  logic [2:0] pinAddr,
  output logic       addrMatch,
  output logic       devRead,
  output logic       txBit,
  output logic       writeBusy
);

  localparam int TW = $clog2(WRITE_CYCLES + 1);
  localparam logic [2:0] PIN_MASK = 3'(3'b111 << HI_BITS);

  logic [7:0]        rxByte, txByte;
  logic [ADDR_W-1:0] addrCnt, wordAddr;
  logic [PAGE_W-1:0] pageNext;
  logic [TW-1:0]     timer;
  logic [7:0]        mem [MEM_BYTES];

  generate
    if (HI_BITS > 0) begin : g_upper
      logic [HI_BITS-1:0] upperReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) upperReg <= '0;
        else if (stb.captureDev) upperReg <= rxByte[HI_BITS:1];
      end
      assign wordAddr = {upperReg, rxByte};
    end else begin : g_flat
      assign wordAddr = rxByte[ADDR_W-1:0];
    end
  endgenerate

  assign pageNext  = addrCnt[PAGE_W-1:0] + PAGE_W'(1);
  assign writeBusy = (timer != '0);
  assign addrMatch = (rxByte[7:4] == 4'b1010)
                   && (((rxByte[3:1] ^ pinAddr) & PIN_MASK) == 3'b000)
                   && !writeBusy;
  assign txBit = txByte[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      txByte  <= '1;
      addrCnt <= '0;
      devRead <= 1'b0;
      timer   <= '0;
    end else begin
      if (stb.shiftRx)    rxByte  <= {rxByte[6:0], sampleBit};
      if (stb.captureDev) devRead <= rxByte[0];
      if (stb.loadWordAddr) addrCnt <= wordAddr;
      if (stb.writeByte)
        addrCnt <= {addrCnt[ADDR_W-1:PAGE_W], pageNext};
      if (stb.loadTx) begin
        txByte  <= mem[addrCnt];
        addrCnt <= addrCnt + ADDR_W'(1);
      end else if (stb.shiftTx) begin
        txByte <= {txByte[6:0], 1'b1};
      end
      if (stb.startTimer)  timer <= TW'(WRITE_CYCLES);
      else if (writeBusy)  timer <= timer - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else if (stb.writeByte) begin
      mem[addrCnt] <= rxByte;
    end
  end

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import seep_pkg::*;
#(
  parameter int DENSITY_KBIT = 2,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaDriveLow,
  input  logic       writeProtect,
  input  logic [2:0] pinAddr
);

  localparam int MEM_BYTES  = DENSITY_KBIT * 128;
  localparam int ADDR_W     = $clog2(MEM_BYTES);
  localparam int PAGE_BYTES = (DENSITY_KBIT <= 2) ? 8 : 16;
  localparam int PAGE_W     = $clog2(PAGE_BYTES);
  localparam int HI_BITS    = (ADDR_W > 8) ? ADDR_W - 8 : 0;

  dpStrobe_t stb;
  logic sampleBit, addrMatch, devRead, txBit, writeBusy;

  seep_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .writeProtect(writeProtect), .addrMatch(addrMatch), .devRead(devRead),
    .txBit(txBit), .sampleBit(sampleBit), .stb(stb), .sdaDriveLow(sdaDriveLow)
  );

  seep_dpath #(
    .MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
    .HI_BITS(HI_BITS), .WRITE_CYCLES(WRITE_CYCLES)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sampleBit(sampleBit),
    .pinAddr(pinAddr), .addrMatch(addrMatch), .devRead(devRead),
    .txBit(txBit), .writeBusy(writeBusy)
  );

endmodule

// File: rtl/seep_checker.sv
module seep_checker #(
  parameter int WRITE_CYCLES = 2000
) (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaIn,
  input logic sdaDriveLow,
  input logic writeBusy
);

  int busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= 0;
    else if (writeBusy) busyLen <= busyLen + 1;
    else busyLen <= 0;
  end

  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !$past(sclIn, 3)); // R12

  AST_SILENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    writeBusy |-> !sdaDriveLow); // R6

  AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeBusy) |-> ($past(sclIn, 3) && $past(sdaIn, 3))); // R6

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeBusy) |-> (busyLen == WRITE_CYCLES)); // R6

endmodule

bind serial_eeprom_slave seep_checker #(.WRITE_CYCLES(WRITE_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
  .sdaDriveLow(sdaDriveLow), .writeBusy(writeBusy)
);

// File: tb/serial_eeprom_slave_tb_top.sv
module serial_eeprom_slave_tb_top;

  localparam int WCYC = 1000;
  localparam int Q    = 10;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, PINS, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, PINS, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic wp = 1'b0;
  logic dutDrive;
  logic sdaBus;

  assign sdaBus = mSda & ~dutDrive;

  always #4 clk = ~clk;

  serial_eeprom_slave #(.DENSITY_KBIT(2), .WRITE_CYCLES(WCYC)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .sdaDriveLow(dutDrive), .writeProtect(wp), .pinAddr(PINS)
  );

  int nChecks = 0;
  int nBad = 0;
  int cyc = 0;
  bit quietWin = 1'b0;
  bit prevDrive = 1'b0;
  logic [7:0] model [256];
  int modelAddr = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the drive against the model's silence windows
  always @(negedge clk) begin
    if (rstN) begin
      if (quietWin) check(!dutDrive, "R6 silent while write cycle runs", dutDrive, 0);
      if (dutDrive && !prevDrive) check(!mScl, "R12 pull-low begins with clock low", mScl, 0);
    end
    prevDrive = dutDrive;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b0; tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic stopCond();
    mSda = 1'b0; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input bit b);
    mSda = b; tick(Q);
    mScl = 1'b1; tick(2 * Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic recvBit(output bit b);
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    b = sdaBus; tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic wrByte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    ack = !b;
  endtask

  task automatic rdByte(input bit giveAck, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
    sendBit(!giveAck);
  endtask

  task automatic poll(output bit ack);
    startCond();
    wrByte(DEV_W, ack);
    stopCond();
  endtask

  task automatic waitReady();
    bit a;
    int t0 = cyc;
    quietWin = 1'b1;
    poll(a);
    quietWin = 1'b0;
    check(!a, "R6 first poll refused", a, 0);
    for (int i = 0; i < 20; i++) begin
      poll(a);
      if (a) break;
    end
    check(a, "R6 acknowledge returns", a, 1);
    check((cyc - t0) >= WCYC && (cyc - t0) <= WCYC + 1200, "R6 write cycle length",
          cyc - t0, WCYC);
  endtask

  task automatic writeSeq(input int word, input logic [7:0] data [$], input bit blocked);
    bit a;
    startCond();
    wrByte(DEV_W, a); check(a, "R2 write address acknowledged", a, 1);
    wrByte(8'(word), a); check(a, "R4 word address acknowledged", a, 1);
    modelAddr = word;
    foreach (data[k]) begin
      wrByte(data[k], a); check(a, "R4 data byte acknowledged", a, 1);
      if (!blocked) model[modelAddr] = data[k];
      modelAddr = (modelAddr & 8'hF8) | ((modelAddr + 1) & 7);
    end
    stopCond();
    if (blocked) begin
      poll(a);
      check(a, "R10 no write cycle under protect", a, 1);
    end else begin
      waitReady();
    end
  endtask

  task automatic readSeq(input bit random, input int word, input int n, input string tag);
    bit a;
    logic [7:0] d;
    if (random) begin
      startCond();
      wrByte(DEV_W, a); check(a, "R8 header acknowledged", a, 1);
      wrByte(8'(word), a); check(a, "R8 word address acknowledged", a, 1);
      modelAddr = word;
    end
    startCond();
    wrByte(DEV_R, a); check(a, "R2 read address acknowledged", a, 1);
    for (int i = 0; i < n; i++) begin
      rdByte(i < n - 1, d);
      check(d == model[modelAddr], tag, d, model[modelAddr]);
      modelAddr = (modelAddr + 1) & 8'hFF;
    end
    stopCond();
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    logic [7:0] q [$];
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    tick(5);
    check(!dutDrive, "R12 released in reset", dutDrive, 0);
    rstN = 1'b1;
    tick(5);
    check(!dutDrive, "R12 released after reset", dutDrive, 0);

    // R3: wrong pin address gets no acknowledge and the slave stays silent
    quietWin = 1'b1;
    startCond();
    wrByte({4'b1010, 3'b001, 1'b0}, a); check(!a, "R3 mismatch refused", a, 0);
    wrByte(8'h00, a); check(!a, "R3 silent after mismatch", a, 0);
    stopCond();
    quietWin = 1'b0;

    // R4 byte write
    q = {8'hA5}; writeSeq(8'h20, q, 1'b0);
    // R5 page write of ten bytes starting near page end
    q = {};
    for (int i = 0; i < 10; i++) q.push_back(8'(8'h30 + i));
    writeSeq(8'h1C, q, 1'b0);
    readSeq(1'b1, 8'h18, 8, "R5 page wrap contents");
    check(model[8'h1E] == 8'h32 && model[8'h18] == 8'h34, "R5 model wrap",
          model[8'h1E], 8'h32);
    // R7 current-address read continues after last byte
    readSeq(1'b0, 0, 1, "R7 current address read");
    // R8 random read
    readSeq(1'b1, 8'h20, 1, "R8 random read");
    // R9 sequential wrap across the array end
    q = {8'h5A}; writeSeq(8'hFF, q, 1'b0);
    q = {8'hC3}; writeSeq(8'h00, q, 1'b0);
    readSeq(1'b1, 8'hFE, 3, "R9 sequential wrap");
    readSeq(1'b0, 0, 1, "R9 read ended on non-acknowledge");
    // R10 write protect
    wp = 1'b1;
    q = {8'h77}; writeSeq(8'h40, q, 1'b1);
    wp = 1'b0;
    readSeq(1'b1, 8'h40, 1, "R10 protected byte unchanged");
    // R11 stop inside a data byte
    startCond();
    wrByte(DEV_W, a);
    wrByte(8'h50, a);
    wrByte(8'h11, a); check(a, "R11 first byte acknowledged", a, 1);
    model[8'h50] = 8'h11;
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    stopCond();
    waitReady();
    readSeq(1'b1, 8'h50, 2, "R11 partial byte discarded");
    // R1 start inside a data byte restarts address reception
    q = {8'h99}; writeSeq(8'h60, q, 1'b0);
    startCond();
    wrByte(DEV_W, a);
    wrByte(8'h60, a);
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b1);
    startCond();
    wrByte(DEV_R, a); check(a, "R1 address after mid-byte start", a, 1);
    rdByte(1'b0, d); check(d == 8'h99, "R1 counter kept, byte not stored", d, 8'h99);
    stopCond();

    tick(20);
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule